// File: doc/BRIEF.md
# Dual-Device NOR Flash Command Sequencer

This block runs the command sequences of a parallel NOR flash array. The array has a 32-bit data bus made of two 16-bit devices side by side. Each command goes out as one 32-bit write, with the 16-bit command code repeated in both halves. Each status check therefore has to look at both devices.

A client starts an operation with a one-cycle request: identify, block erase or word program. The sequencer then issues every bus write and read the operation needs. It polls the status word until both devices are ready, or until a programmable limit on the number of polls runs out. It then puts the array back into array-read mode and returns one result code on a single-cycle `done` pulse.

The bus side is a simple master port. A transfer is held until the slave acknowledges it. Line permutation on the board and bus timing are handled outside the block.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, `bus_req` is 0 and `done` is 0.
- R2: Identify (`req_op`=0) issues these transfers in order:
  - write 0x00900090 to address 0;
  - read address 0;
  - read address 4;
  - write 0x00FF00FF to address 0.
  It gives result 0 (pass) only if the first read is 0x00890089 and the second is 0x88F388F3 or 0x88F488F4. Otherwise it gives result 1 (fail).
- R3: Block erase (`req_op`=1) writes 0x00200020 and then 0x00D000D0 to the request address, and then enters status polling.
- R4: Each status poll writes 0x00700070 to the target address and then reads the status word there. Polling repeats until both bits under mask 0x00800080 are set. A word with only one of those bits set keeps the poll going.
- R5: Once polling ends, for any reason, 0x00FF00FF is written to the target address before `done` rises.
- R6: An erase gives result 1 if either bit under mask 0x00200020 is set in the final status word. Otherwise it gives result 0. Bits under 0x00100010 do not affect an erase.
- R7: Word program (`req_op`=2) runs these steps:
  - writes 0x00400040, then `req_data`, to the request address;
  - polls as in R4;
  - restores as in R5;
  - reads the address once more.
  It gives result 1 if either bit under 0x00100010 is set in the final status word, or if the read-back differs from `req_data`. Otherwise it gives result 0.
- R8: Let L be `poll_limit`, sampled at the request, with 0 treated as 1. If L status reads in a row all show a clear ready bit, polling stops. The read-array restore is written, no program read-back follows, and the result is 2 (timeout).
- R9: The request is rejected with result 3 on the `done` pulse in the cycle after it is accepted, and no bus transfer takes place, in either of these cases:
  - an erase or program whose address has bits [1:0] not equal to 0;
  - a request with `req_op`=3.
- R10: A bus transfer keeps its address, direction and write data steady until `bus_ack`. `done` lasts exactly one cycle and is never high together with `bus_req`. `req_ready` is low while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Starts an operation when `req_ready` is high |
| req_op | input | 2 | 0 identify, 1 block erase, 2 word program, 3 invalid |
| req_addr | input | AW | Byte address of the target (ignored for identify) |
| req_data | input | 32 | Word to program |
| poll_limit | input | TW | Maximum number of status reads |
| req_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 pass, 1 fail, 2 timeout, 3 rejected; valid with `done` |
| bus_req | output | 1 | Bus transfer pending |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Transfer byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Slave completes the pending transfer |

## Verification
The properties assume the slave raises `bus_ack` only while `bus_req` is high, and that `req_valid` is offered only while `req_ready` is high. The bench's flash model acknowledges every transfer after one wait cycle and never acknowledges when idle. The bench also raises a request only after the previous `done` pulse has been seen. While busy, the model returns a status word with only the lower device ready. This holds the poll loop in its mixed state for as many reads as each test asks.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW = 24,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_data,
  input  logic [TW-1:0] poll_limit,
  output logic          req_ready,
  output logic          done,
  output logic [1:0]    result,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack
);
  localparam logic [31:0] C_ARRAY = 32'h00FF00FF;
  localparam logic [31:0] C_IDENT = 32'h00900090;
  localparam logic [31:0] C_ESET  = 32'h00200020;
  localparam logic [31:0] C_ECONF = 32'h00D000D0;
  localparam logic [31:0] C_PSET  = 32'h00400040;
  localparam logic [31:0] C_STAT  = 32'h00700070;
  localparam logic [31:0] M_READY = 32'h00800080;
  localparam logic [31:0] M_EERR  = 32'h00200020;
  localparam logic [31:0] M_PERR  = 32'h00100010;
  localparam logic [31:0] ID_MAN  = 32'h00890089;
  localparam logic [31:0] ID_DTOP = 32'h88F388F3;
  localparam logic [31:0] ID_DBOT = 32'h88F488F4;
  localparam logic [1:0] OP_ID = 2'd0, OP_ER = 2'd1, OP_PG = 2'd2;
  localparam logic [1:0] RS_OK = 2'd0, RS_FAIL = 2'd1, RS_TMO = 2'd2, RS_REJ = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_CMD2, S_PW, S_PR, S_ID0, S_ID1, S_REST, S_VER
  } st_t;

  st_t           st;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   data_q;
  logic [TW-1:0] lim_q, cnt;
  logic          fail_q, tmo_q;

  wire xfer     = bus_req & bus_ack;
  wire rdy_both = (bus_rdata & M_READY) == M_READY;
  wire st_err   = |(bus_rdata & ((op_q == OP_PG) ? M_PERR : M_EERR));
  wire poll_end = ({1'b0, cnt} + 1'b1) >= {1'b0, lim_q};
  wire bad_req  = (req_op == 2'd3) || (req_op != OP_ID && req_addr[1:0] != 2'b00);

  assign req_ready = (st == S_IDLE);
  assign bus_req   = (st != S_IDLE);
  assign bus_we    = st inside {S_CMD1, S_CMD2, S_PW, S_REST};
  assign bus_addr  = (op_q != OP_ID) ? addr_q :
                     (st == S_ID1) ? AW'(4) : '0;

  always_comb begin
    case (st)
      S_CMD1:  bus_wdata = (op_q == OP_ID) ? C_IDENT : (op_q == OP_ER) ? C_ESET : C_PSET;
      S_CMD2:  bus_wdata = (op_q == OP_ER) ? C_ECONF : data_q;
      S_PW:    bus_wdata = C_STAT;
      S_REST:  bus_wdata = C_ARRAY;
      default: bus_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; result <= RS_OK;
      op_q <= OP_ID; addr_q <= '0; data_q <= '0; lim_q <= '0; cnt <= '0;
      fail_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= req_op; addr_q <= req_addr; data_q <= req_data; lim_q <= poll_limit;
          cnt <= '0; fail_q <= 1'b0; tmo_q <= 1'b0;
          if (bad_req) begin
            done <= 1'b1; result <= RS_REJ;
          end else st <= S_CMD1;
        end
        S_CMD1: if (xfer) st <= (op_q == OP_ID) ? S_ID0 : S_CMD2;
        S_CMD2: if (xfer) st <= S_PW;
        S_PW:   if (xfer) st <= S_PR;
        S_PR: if (xfer) begin
          if (rdy_both) begin
            fail_q <= st_err; st <= S_REST;
          end else if (poll_end) begin
            tmo_q <= 1'b1; st <= S_REST;
          end else begin
            cnt <= cnt + 1'b1; st <= S_PW;
          end
        end
        S_ID0: if (xfer) begin
          fail_q <= (bus_rdata != ID_MAN); st <= S_ID1;
        end
        S_ID1: if (xfer) begin
          fail_q <= fail_q | ~(bus_rdata == ID_DTOP || bus_rdata == ID_DBOT);
          st <= S_REST;
        end
        S_REST: if (xfer) begin
          if (op_q == OP_PG && !tmo_q) st <= S_VER;
          else begin
            st <= S_IDLE; done <= 1'b1;
            result <= tmo_q ? RS_TMO : fail_q ? RS_FAIL : RS_OK;
          end
        end
        S_VER: if (xfer) begin
          st <= S_IDLE; done <= 1'b1;
          result <= (fail_q || bus_rdata != data_q) ? RS_FAIL : RS_OK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic          req_ready,
  input logic          done,
  input logic [1:0]    result,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_ack
);
  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req && req_ready);

  // R9
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_op == 2'd3 || (req_op != 2'd0 && req_addr[1:0] != 2'b00))
    |=> done && result == 2'd3 && !bus_req);

  // R8
  tmo_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && result == 2'd2 |-> $past(bus_we) && $past(bus_wdata) == 32'h00FF00FF);

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !bus_req && !done);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
  .req_ready(req_ready), .done(done), .result(result), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [TW-1:0] poll_limit = '0;
  logic req_ready, done, bus_req, bus_we;
  logic [1:0] result;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic bus_ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq #(.AW(AW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .poll_limit(poll_limit), .req_ready(req_ready), .done(done),
    .result(result), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  // flash array model: two devices seen as one 32-bit word
  logic [3:0]  cfg_busy = '0;
  logic [31:0] cfg_err = '0, cfg_man = 32'h00890089, cfg_dev = 32'h88F388F3;
  logic        cfg_corrupt = 1'b0;
  logic [31:0] mem [16];
  logic [31:0] wlog [16];
  logic [AW-1:0] alog [16];
  int nwr = 0, nrd = 0;
  logic [1:0] mode = 2'd0;
  logic pend_er = 1'b0, pend_pg = 1'b0;
  logic [3:0] busy_left = '0;
  logic ack_r = 1'b0;
  logic [31:0] rd_r = '0;
  assign bus_ack = ack_r;
  assign bus_rdata = rd_r;

  always @(posedge clk) begin
    ack_r <= 1'b0;
    if (rst_n && bus_req && !ack_r) begin
      ack_r <= 1'b1;
      if (bus_we) begin
        wlog[nwr % 16] <= bus_wdata;
        alog[nwr % 16] <= bus_addr;
        nwr <= nwr + 1;
        if (pend_pg) begin
          mem[bus_addr[5:2]] <= cfg_corrupt ? (bus_wdata ^ 32'h1) : bus_wdata;
          pend_pg <= 1'b0; busy_left <= cfg_busy; mode <= 2'd2;
        end else begin
          case (bus_wdata)
            32'h00FF00FF: mode <= 2'd0;
            32'h00900090: mode <= 2'd1;
            32'h00700070: mode <= 2'd2;
            32'h00200020: pend_er <= 1'b1;
            32'h00400040: pend_pg <= 1'b1;
            32'h00D000D0: if (pend_er) begin
              pend_er <= 1'b0; busy_left <= cfg_busy; mode <= 2'd2;
            end
            default: ;
          endcase
        end
      end else begin
        nrd <= nrd + 1;
        case (mode)
          2'd1: rd_r <= (bus_addr == '0) ? cfg_man : cfg_dev;
          2'd2: if (busy_left != 0) begin
                  rd_r <= 32'h00000080; busy_left <= busy_left - 1'b1;
                end else rd_r <= 32'h00800080 | cfg_err;
          default: rd_r <= mem[bus_addr[5:2]];
        endcase
      end
    end
  end

  int n_chk = 0, n_fail = 0, cyc_all = 0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 150000);
      summary();
    end
  end

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  busy;
    logic [31:0] err;
    logic        corrupt;
    logic [31:0] man;
    logic [31:0] dev;
    logic [7:0]  lim;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 8'h00, 32'h0, 4'd0, 32'h0, 1'b0, 32'h00890089, 32'h88F388F3, 8'd4, 2'd0}, // R2
    '{2'd0, 8'h00, 32'h0, 4'd0, 32'h0, 1'b0, 32'h00890089, 32'h88F488F4, 8'd4, 2'd0}, // R2
    '{2'd0, 8'h00, 32'h0, 4'd0, 32'h0, 1'b0, 32'h00890089, 32'h88F188F1, 8'd4, 2'd1}, // R2
    '{2'd0, 8'h00, 32'h0, 4'd0, 32'h0, 1'b0, 32'h00890088, 32'h88F388F3, 8'd4, 2'd1}, // R2
    '{2'd1, 8'h40, 32'h0, 4'd3, 32'h0, 1'b0, 32'h00890089, 32'h88F388F3, 8'd20, 2'd0}, // R3
    '{2'd1, 8'h10, 32'h0, 4'd0, 32'h00200000, 1'b0, 32'h00890089, 32'h88F388F3, 8'd20, 2'd1}, // R6
    '{2'd1, 8'h14, 32'h0, 4'd1, 32'h00100010, 1'b0, 32'h00890089, 32'h88F388F3, 8'd20, 2'd0}, // R6
    '{2'd2, 8'h08, 32'hA5A55A5A, 4'd2, 32'h0, 1'b0, 32'h00890089, 32'h88F388F3, 8'd20, 2'd0}, // R7
    '{2'd2, 8'h0C, 32'h12345678, 4'd1, 32'h00000010, 1'b0, 32'h00890089, 32'h88F388F3, 8'd20, 2'd1}, // R7
    '{2'd2, 8'h20, 32'hFFFF0000, 4'd0, 32'h0, 1'b1, 32'h00890089, 32'h88F388F3, 8'd20, 2'd1}, // R7
    '{2'd1, 8'h30, 32'h0, 4'd5, 32'h0, 1'b0, 32'h00890089, 32'h88F388F3, 8'd3, 2'd2}, // R8
    '{2'd2, 8'h24, 32'hCAFEF00D, 4'd4, 32'h0, 1'b0, 32'h00890089, 32'h88F388F3, 8'd5, 2'd0}, // R4
    '{2'd2, 8'h28, 32'h0BADBEEF, 4'd5, 32'h0, 1'b0, 32'h00890089, 32'h88F388F3, 8'd5, 2'd2}, // R8
    '{2'd1, 8'h04, 32'h0, 4'd2, 32'h0, 1'b0, 32'h00890089, 32'h88F388F3, 8'd0, 2'd2}  // R8
  };

  task automatic run_op(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d,
                        input logic [7:0] lim, output logic [1:0] res, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = d; poll_limit = TW'(lim);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    res = result;
    check(done, "R10 done seen", {31'd0, done}, 32'd1);
    @(negedge clk);
    check(!done, "R10 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    logic [1:0] res;
    int cyc, w0, r0, polls, ew, er, leff;
    logic tmo;
    for (int i = 0; i < 16; i++) mem[i] = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    // R1
    check(req_ready && !bus_req && !done, "R1 reset state", {29'd0, req_ready, bus_req, done}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !bus_req && !done, "R1 after release", {29'd0, req_ready, bus_req, done}, 32'h4);

    for (int v = 0; v < NV; v++) begin
      cfg_busy = TBL[v].busy; cfg_err = TBL[v].err; cfg_corrupt = TBL[v].corrupt;
      cfg_man = TBL[v].man; cfg_dev = TBL[v].dev;
      w0 = nwr; r0 = nrd;
      run_op(TBL[v].op, TBL[v].addr, TBL[v].data, TBL[v].lim, res, cyc);
      check(res == TBL[v].exp, $sformatf("R2/R6/R7/R8 result vec %0d", v), {30'd0, res}, {30'd0, TBL[v].exp});
      leff = (TBL[v].lim == 0) ? 1 : int'(TBL[v].lim);
      tmo = int'(TBL[v].busy) >= leff;
      polls = tmo ? leff : int'(TBL[v].busy) + 1;
      if (TBL[v].op == 2'd0) begin ew = 2; er = 2; end
      else begin ew = 3 + polls; er = polls + ((TBL[v].op == 2'd2 && !tmo) ? 1 : 0); end
      check(nwr - w0 == ew, $sformatf("R4 write count vec %0d", v), 32'(nwr - w0), 32'(ew));
      check(nrd - r0 == er, $sformatf("R4 R8 read count vec %0d", v), 32'(nrd - r0), 32'(er));
      check(wlog[(nwr - 1) % 16] == 32'h00FF00FF, $sformatf("R5 last write vec %0d", v),
            wlog[(nwr - 1) % 16], 32'h00FF00FF);
      case (TBL[v].op)
        2'd0: begin
          check(wlog[w0 % 16] == 32'h00900090 && alog[w0 % 16] == '0, "R2 ident cmd",
                wlog[w0 % 16], 32'h00900090);
          check(alog[(nwr - 1) % 16] == '0, "R2 restore at 0", 32'(alog[(nwr - 1) % 16]), 32'h0);
        end
        2'd1: begin
          check(wlog[w0 % 16] == 32'h00200020, "R3 erase setup", wlog[w0 % 16], 32'h00200020);
          check(wlog[(w0 + 1) % 16] == 32'h00D000D0 && alog[(w0 + 1) % 16] == AW'(TBL[v].addr),
                "R3 erase confirm", wlog[(w0 + 1) % 16], 32'h00D000D0);
          check(wlog[(w0 + 2) % 16] == 32'h00700070, "R4 status cmd", wlog[(w0 + 2) % 16], 32'h00700070);
        end
        default: begin
          check(wlog[w0 % 16] == 32'h00400040, "R7 program setup", wlog[w0 % 16], 32'h00400040);
          check(wlog[(w0 + 1) % 16] == TBL[v].data && alog[(w0 + 1) % 16] == AW'(TBL[v].addr),
                "R7 program data", wlog[(w0 + 1) % 16], TBL[v].data);
        end
      endcase
    end

    // R9 misaligned and invalid requests
    w0 = nwr; r0 = nrd;
    run_op(2'd1, 8'h42, 32'h0, 8'd4, res, cyc);
    check(res == 2'd3, "R9 misaligned erase", {30'd0, res}, 32'd3);
    check(cyc == 1, "R9 reject latency", 32'(cyc), 32'd1);
    run_op(2'd2, 8'h41, 32'h1, 8'd4, res, cyc);
    check(res == 2'd3, "R9 misaligned program", {30'd0, res}, 32'd3);
    run_op(2'd3, 8'h00, 32'h0, 8'd4, res, cyc);
    check(res == 2'd3, "R9 invalid op", {30'd0, res}, 32'd3);
    check(nwr == w0 && nrd == r0, "R9 no bus activity", 32'(nwr - w0 + nrd - r0), 32'd0);

    // R10 busy flag during an operation
    cfg_busy = 4'd2; cfg_err = '0; cfg_corrupt = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = AW'(8'h18); poll_limit = TW'(8);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready && bus_req, "R10 busy during op", {30'd0, req_ready, bus_req}, 32'h1);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    check(done && result == 2'd0, "R3 R10 erase completes", {30'd0, result}, 32'd0);
    @(negedge clk);

    // R1 reset mid-operation
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2; req_addr = AW'(8'h1C); req_data = 32'h5;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(req_ready && !bus_req && !done, "R1 reset aborts", {29'd0, req_ready, bus_req, done}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule